// File: doc/BRIEF.md
# Fixed-Cycle Countdown Timer Interrupt

This block produces a periodic interrupt for a real-time clock. One of four tick sources is chosen by a two-bit code: a 4096 Hz enable, a 64 Hz enable, the seconds-update event and the minutes-update event. The seconds and minutes events come from the calendar core, so those two rates follow the calendar rather than a free-running divider. An eight-bit reload value N sets the period to N ticks of the chosen source. When the count runs out, a sticky event flag is set and the counter reloads, so the timer keeps running until software stops it.

Software reaches the timer through a small register port with one write strobe and a combinational read port. Through it, software sets the source code, the reload value, a run bit and an interrupt enable. It also reads and clears the event flag. The interrupt pin is active-low and released when idle, and is modelled as an output-enable `int_oe`. The interrupt works in level mode: a pending event stays pending while the enable is off. If the enable is then set, the pin drives low straight away.

Because the first source tick arrives at an arbitrary point after the timer starts, the first interval can be up to one source period shorter than the set time. Every later interval is exactly N ticks.

Top module: `cdt_timer`

## Requirements
- R1: After reset `int_oe` is 0 and every register reads 0. Register addresses: 0 is control, 1 is reload value, 2 is current count (read only), 3 reads 0. Control bits: bit 0 is run, bit 1 is interrupt enable, bit 2 is event flag, bits 5:4 are the source code, and the other bits read 0.
- R2: Only the tick input picked by the source code advances the counter. Code 0 picks `src_tick[0]` (4096 Hz), code 1 picks `src_tick[1]` (64 Hz), code 2 picks `src_tick[2]` (seconds update) and code 3 picks `src_tick[3]` (minutes update). Pulses on the other inputs leave the count unchanged.
- R3: With run at 1 and reload N from 1 to 255, each selected tick lowers the count by one. The N-th tick after start or reload sets the event flag and loads N back into the counter, so a further event follows every N ticks.
- R4: A reload value of 0 never sets the event flag.
- R5: While run is 0, the count reads back the reload value and ticks cause no event.
- R6: `int_oe` is 1 exactly while both the flag and the interrupt enable are 1. Clearing the enable releases the output but leaves the flag set.
- R7: Setting the enable while the flag is pending drives `int_oe` to 1 in the cycle after the write.
- R8: A control write with bit 2 at 0 clears the flag. A control write with bit 2 at 1 leaves the flag as it was.
- R9: If an expiry and a flag-clearing write fall in the same cycle, the flag ends up set.
- R10: A write to the reload register loads the new value into the counter at once. This write wins over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | 4 | Single-cycle tick enables, one per source rate |
| reg_addr | input | 2 | Register address for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| int_oe | output | 1 | 1 drives the active-low interrupt pin low, 0 releases it |

## Verification
Two kinds of events can land in the same clock edge. The first is a countdown expiry together with a software write that clears the flag. The second is a selected tick together with a write of a new reload value. The bench causes each collision by setting the write strobe and the tick on the same falling edge. The outcome is judged at the ports: the flag must stay set in the first case, and the count must read the newly written value in the second. Interval counts are swept for every source code and several reload values, with pulses on the unselected sources placed between the selected ticks.

// File: rtl/cdt_pkg.sv
// Package: shared register addresses, control-field positions and the
// source-code type for the fixed-cycle countdown timer.
package cdt_pkg;

    // Register addresses
    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_COUNT  = 2'd2;

    // Control register bit positions
    localparam int CTRL_RUN  = 0;
    localparam int CTRL_IE   = 1;
    localparam int CTRL_FLAG = 2;
    localparam int CTRL_SEL  = 4;

    // Tick source codes
    typedef enum logic [1:0] {
        SRC_FAST   = 2'd0,
        SRC_SLOW   = 2'd1,
        SRC_SECOND = 2'd2,
        SRC_MINUTE = 2'd3
    } src_sel_e;

endpackage

// File: rtl/cdt_tick_mux.sv
// Module: cdt_tick_mux
// Picks one tick-enable from NUM_SRC inputs according to the select code.
// Assumes each tick input is a single-cycle pulse synchronous to clk.
module cdt_tick_mux #(
    parameter int NUM_SRC = 4,
    localparam int SEL_W = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   sel,
    output logic               tick
);

    logic [NUM_SRC-1:0] hit;

    // One match term per source: a tick counts only while its code is selected
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = src_tick[i] && (sel == SEL_W'(i));
    end

    // Combine the match terms into the single tick
    always_comb begin
        tick = |hit;
    end

endmodule

// File: rtl/cdt_regs.sv
// Module: cdt_regs
// Holds the software-visible control state: run, interrupt enable, source
// code and reload value. It also decodes the write strobes that touch the
// counter (reload write) and the event flag (flag clear).
// Assumes DATA_W is wide enough to hold the control fields.
module cdt_regs #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              run,
    output logic              irq_en,
    output logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] reload,
    output logic              reload_wr,
    output logic              flag_clr
);
    import cdt_pkg::*;

    logic ctrl_wr;

    // Decode which register the current write targets
    always_comb begin
        ctrl_wr   = wr && (addr == ADDR_CTRL);
        reload_wr = wr && (addr == ADDR_RELOAD);
        flag_clr  = ctrl_wr && !wdata[CTRL_FLAG];
    end

    // Control register: run, interrupt enable and source code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            irq_en <= 1'b0;
            sel    <= '0;
        end else if (ctrl_wr) begin
            run    <= wdata[CTRL_RUN];
            irq_en <= wdata[CTRL_IE];
            sel    <= wdata[CTRL_SEL +: SEL_W];
        end
    end

    // Reload value register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
        end else if (reload_wr) begin
            reload <= wdata;
        end
    end

endmodule

// File: rtl/cdt_down_counter.sv
// Module: cdt_down_counter
// Reloadable down-counter. It steps on each tick while running and reports
// expiry when the last tick of a period arrives, then reloads itself.
// Assumes a reload value of zero means the counter is idle.
module cdt_down_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic armed;

    // Expiry happens on a live tick at the last count of a nonzero period
    always_comb begin
        armed  = (reload_val != '0);
        expire = run && tick && !load && armed && (cnt <= ONE);
    end

    // Count state: a load beats the stop hold, and the stop hold beats counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (!run) begin
            cnt <= reload_val;
        end else if (tick && armed) begin
            cnt <= expire ? reload_val : cnt - ONE;
        end
    end

endmodule

// File: rtl/cdt_irq.sv
// Module: cdt_irq
// Sticky event flag with a level-mode interrupt output-enable.
// Assumes set and clear requests are single-cycle and synchronous to clk.
module cdt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic irq_en,
    output logic flag,
    output logic int_oe
);

    // Event flag: a set wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr_evt) begin
            flag <= 1'b0;
        end
    end

    // Level-mode output: drive low whenever the flag is pending and enabled
    always_comb begin
        int_oe = flag && irq_en;
    end

endmodule

// File: rtl/cdt_timer.sv
// Module: cdt_timer
// Fixed-cycle countdown timer with a periodic interrupt. It selects a tick
// source, counts down a reload value and raises a sticky flag at expiry.
// Assumes the tick inputs come from the clock core as one-cycle pulses.
module cdt_timer #(
    parameter int NUM_SRC = 4,
    parameter int CNT_W   = 8,
    localparam int SEL_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [1:0]         reg_addr,
    input  logic               reg_wr,
    input  logic [CNT_W-1:0]   reg_wdata,
    output logic [CNT_W-1:0]   reg_rdata,
    output logic               int_oe
);
    import cdt_pkg::*;

    logic             run;
    logic             irq_en;
    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] reload;
    logic             reload_wr;
    logic             flag_clr;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             expire;
    logic             flag;

    cdt_regs #(.DATA_W(CNT_W), .SEL_W(SEL_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .run       (run),
        .irq_en    (irq_en),
        .sel       (sel),
        .reload    (reload),
        .reload_wr (reload_wr),
        .flag_clr  (flag_clr)
    );

    cdt_tick_mux #(.NUM_SRC(NUM_SRC)) i_mux (
        .src_tick (src_tick),
        .sel      (sel),
        .tick     (tick)
    );

    cdt_down_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .tick       (tick),
        .load       (reload_wr),
        .load_val   (reg_wdata),
        .reload_val (reload),
        .cnt        (cnt),
        .expire     (expire)
    );

    cdt_irq i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (expire),
        .clr_evt (flag_clr),
        .irq_en  (irq_en),
        .flag    (flag),
        .int_oe  (int_oe)
    );

    // Read mux: assemble the control word or return the addressed register
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTRL_RUN]           = run;
                reg_rdata[CTRL_IE]            = irq_en;
                reg_rdata[CTRL_FLAG]          = flag;
                reg_rdata[CTRL_SEL +: SEL_W]  = sel;
            end
            ADDR_RELOAD: reg_rdata = reload;
            ADDR_COUNT:  reg_rdata = cnt;
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cdt_timer_chk.sv
// Module: cdt_timer_chk
// Checker for cdt_timer, bound into it. It relates the register state,
// counter and interrupt output across cycles.
module cdt_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             irq_en,
    input logic             flag,
    input logic             expire,
    input logic             reload_wr,
    input logic             flag_clr,
    input logic [CNT_W-1:0] reload,
    input logic [CNT_W-1:0] cnt,
    input logic             int_oe
);

    // R1: output released in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !int_oe);

    // R4: a zero period never expires
    p_zero_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reload == '0) |-> !expire);

    // R5: while stopped the counter follows the reload value
    p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload_wr) |=> (cnt == $past(reload)));

    // R3: expiry reloads the counter
    p_expire_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !reload_wr) |=> (cnt == $past(reload)));

    // R6: a disabled interrupt never drives the pin
    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !int_oe);

    // R7: enabling with a pending flag drives the pin at once
    p_level_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_en) && flag) |-> int_oe);

    // R9: an expiry leaves the flag set even against a clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && flag_clr) |=> flag);

endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .irq_en    (irq_en),
    .flag      (flag),
    .expire    (expire),
    .reload_wr (reload_wr),
    .flag_clr  (flag_clr),
    .reload    (reload),
    .cnt       (cnt),
    .int_oe    (int_oe)
);

// File: tb/test_cdt_timer.sv
// Bench for cdt_timer: sweeps every source code over several reload values
// and provokes the same-cycle collisions. Expected values are arithmetic.
module test_cdt_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] src_tick = '0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       int_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    cdt_timer i_cdt_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_tick  (src_tick),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .int_oe    (int_oe)
    );

    function automatic logic [7:0] ctrl(input logic [1:0] s, input logic fl,
                                        input logic ie, input logic rn);
        return {2'b00, s, 1'b0, fl, ie, rn};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d,
                      input logic [3:0] tk);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; src_tick = tk;
        @(negedge clk);
        reg_wr = 1'b0; src_tick = '0;
    endtask

    task automatic pulse(input logic [3:0] tk);
        @(negedge clk);
        src_tick = tk;
        @(negedge clk);
        src_tick = '0;
    endtask

    task automatic flag_is(input string req, input int exp);
        logic [7:0] d;
        rd(2'd0, d);
        check(req, int'(d[2]), exp);
    endtask

    task automatic count_is(input string req, input int exp);
        logic [7:0] d;
        rd(2'd2, d);
        check(req, int'(d), exp);
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 int_oe", int'(int_oe), 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R1 reg", int'(d), 0);
        end

        // R2/R3: sweep source codes and reload values
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 4; k++) begin
                int n;
                logic [3:0] me;
                n  = (k == 3) ? 7 : k + 1;
                me = 4'b0001 << s;
                wr(2'd1, 8'(n), '0);
                wr(2'd0, ctrl(2'(s), 1'b0, 1'b1, 1'b1), '0);
                count_is("R3 start count", n);
                for (int p = 0; p < 2; p++) begin
                    for (int t = 1; t <= n; t++) begin
                        pulse(~me);
                        count_is("R2 other source ignored", (t == 1) ? n : n - t + 1);
                        pulse(me);
                        count_is("R3 count", (t == n) ? n : n - t);
                        flag_is("R3 flag", (t == n) ? 1 : 0);
                        check("R6 int_oe", int'(int_oe), (t == n) ? 1 : 0);
                    end
                    wr(2'd0, ctrl(2'(s), 1'b0, 1'b1, 1'b1), '0);
                    flag_is("R8 clear", 0);
                end
                wr(2'd0, ctrl(2'(s), 1'b0, 1'b0, 1'b0), '0);
            end
        end

        // R4: zero reload never fires
        wr(2'd1, 8'd0, '0);
        wr(2'd0, ctrl(2'd1, 1'b0, 1'b1, 1'b1), '0);
        for (int t = 0; t < 10; t++) pulse(4'b0010);
        flag_is("R4 no event", 0);
        check("R4 int_oe", int'(int_oe), 0);

        // R5: stopped timer holds the reload value
        wr(2'd1, 8'd4, '0);
        wr(2'd0, ctrl(2'd1, 1'b0, 1'b1, 1'b0), '0);
        for (int t = 0; t < 6; t++) pulse(4'b1111);
        count_is("R5 hold", 4);
        flag_is("R5 no event", 0);

        // R6/R7/R8: level mode with enable toggling
        wr(2'd1, 8'd2, '0);
        wr(2'd0, ctrl(2'd0, 1'b0, 1'b0, 1'b1), '0);
        pulse(4'b0001);
        pulse(4'b0001);
        flag_is("R6 flag while disabled", 1);
        check("R6 released while disabled", int'(int_oe), 0);
        wr(2'd0, ctrl(2'd0, 1'b1, 1'b1, 1'b1), '0);
        check("R7 immediate assert", int'(int_oe), 1);
        flag_is("R8 write one keeps flag", 1);
        wr(2'd0, ctrl(2'd0, 1'b1, 1'b0, 1'b1), '0);
        check("R6 release on disable", int'(int_oe), 0);
        flag_is("R6 flag kept", 1);
        wr(2'd0, ctrl(2'd0, 1'b0, 1'b1, 1'b1), '0);
        flag_is("R8 cleared", 0);
        check("R8 int_oe released", int'(int_oe), 0);

        // R9: expiry collides with a clearing write
        pulse(4'b0001);
        wr(2'd0, ctrl(2'd0, 1'b0, 1'b1, 1'b1), 4'b0001);
        flag_is("R9 set wins", 1);
        check("R9 int_oe", int'(int_oe), 1);
        wr(2'd0, ctrl(2'd0, 1'b0, 1'b1, 1'b1), '0);

        // R10: reload write collides with a tick
        wr(2'd1, 8'd5, '0);
        pulse(4'b0001);
        pulse(4'b0001);
        count_is("R10 pre count", 3);
        wr(2'd1, 8'd2, 4'b0001);
        count_is("R10 load wins", 2);
        pulse(4'b0001);
        flag_is("R10 not yet", 0);
        pulse(4'b0001);
        flag_is("R10 new period", 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule